// File: doc/BRIEF.md
# Shared-Bus Multi-Port SPI Master

This block is an SPI master that runs eight logical ports over one clock line, one data-out line and one data-in line. Each chip-select line serves two ports. Port `p` asserts chip select `p/2`. Because the three data lines are shared, only one port can be active at a time.

The host sets up a transfer through level inputs: enable, port number, clock polarity, clock phase, bit order, clock divider and inter-byte gap. It then offers bytes one at a time on a valid/ready command pair, and flags the final byte of the transfer. All settings are captured when the first byte is accepted. Each received byte is returned with a one-cycle strobe.

When the last byte finishes, chip select is released and a completion pulse is raised. A request that the chosen port cannot serve is refused with a one-cycle error pulse and never reaches the bus. An output-enable signal tells the pad logic when the bus lines are to be driven.

Top module: `spi_multiport_master`

## Requirements
- R1: While a transfer runs, only `cs_n[port_sel>>1]` is low. All other chip selects are high, and at most one chip select is ever low.
- R2: An even-numbered port accepts only CPHA=0 (modes 0 and 2). A command in the idle state with CPHA=1 on an even port is consumed and rejected. `err` then pulses high for one cycle, in the cycle after acceptance, and no chip select falls.
- R3: CPHA=1 (modes 1 and 3) is refused with the same `err` behaviour when `clk_div` lies outside `[SLOW_DIV_MIN, SLOW_DIV_MAX]` (defaults 4 and 20).
- R4: A command with `port_en` low is rejected with `err`. `bus_oe` is high while `port_en` is high or a transfer is in progress. It is low otherwise.
- R5: One half SCK period is `clk_div+1` clock cycles. SCK rests at CPOL, makes 16 edges per byte, and does not move while all chip selects are high.
- R6: With CPHA=0, MOSI carries the first bit in the cycle where chip select falls. MISO is sampled on each leading SCK edge, and MOSI advances on each trailing edge.
- R7: With CPHA=1, MOSI is updated on each leading SCK edge and MISO is sampled on each trailing edge.
- R8: With `lsb_first`=1, bit 0 is sent and received first. With `lsb_first`=0, bit 7 comes first.
- R9: Between bytes, SCK stays at CPOL and chip select stays low for `gap_len` half periods. `cmd_ready` then rises for the next byte. With `gap_len`=0 it rises right after the last edge.
- R10: `rx_valid` pulses for one cycle after a byte's last SCK edge, with the received byte on `rx_data`.
- R11: One half period after the final byte's last edge, chip select rises. `done` pulses in that same cycle, and `rx_data` still holds the final byte.
- R12: Changing polarity, bit order or divider inputs during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; bus lines driven while high |
| port_sel | input | 3 | Logical port number |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase |
| lsb_first | input | 1 | 1 = least significant bit first |
| clk_div | input | 8 | Half SCK period minus one, in clock cycles |
| gap_len | input | 10 | Inter-byte gap in half SCK periods |
| cmd_valid | input | 1 | Byte offered |
| cmd_data | input | 8 | Byte to send |
| cmd_last | input | 1 | Offered byte ends the transfer |
| cmd_ready | output | 1 | Byte accepted this cycle when valid |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Request refused pulse |
| sck | output | 1 | Shared serial clock |
| mosi | output | 1 | Shared serial data out |
| miso | input | 1 | Shared serial data in |
| cs_n | output | 4 | Active-low chip selects |
| bus_oe | output | 1 | Output enable for bus and chip-select pads |

## Verification
Two events can land in the same cycle. The final byte's chip-select release coincides with the `done` pulse, and the last MISO sample of a byte coincides with the `rx_valid` capture that must already include it. The bench provokes both with single-byte and multi-byte transfers at several dividers, including a divider of zero where every cycle is an SCK edge. A behavioural model predicts chip select, SCK, MOSI, ready, strobes and data for every clock, and each prediction is compared against the outputs. A further run changes polarity, bit order and divider halfway through a byte, and is judged against the waveform of the original settings.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_NEED,
        ST_TAIL
    } spim_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb;
    } spim_mode_t;

    // position inside the word of the k-th bit on the wire
    function automatic int unsigned bit_slot(int unsigned k, logic lsb, int unsigned w);
        return lsb ? k : (w - 1 - k);
    endfunction

    // even ports serve only CPHA=0; CPHA=1 has a narrow divider window
    function automatic logic mode_ok(logic port_odd, logic cpha, int unsigned div,
                                     int unsigned lo, int unsigned hi);
        if (!cpha)
            return 1'b1;
        return port_odd && (div >= lo) && (div <= hi);
    endfunction

endpackage

// File: rtl/spim_tickgen.sv
module spim_tickgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int WORD_W       = 8,
    parameter int DIV_W        = 8,
    parameter int GAP_W        = 10,
    parameter int PORT_W       = 3,
    parameter int SLOW_DIV_MIN = 4,
    parameter int SLOW_DIV_MAX = 20,
    localparam int CS_W        = PORT_W - 1,
    localparam int EDGE_W      = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [PORT_W-1:0] port_sel,
    input  spim_mode_t        mode_in,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic              cmd_valid,
    input  logic              cmd_last,
    input  logic              tick,
    output logic              cmd_ready,
    output logic              load,
    output logic              edge_stb,
    output logic [EDGE_W-1:0] edge_idx,
    output logic              byte_end,
    output logic              run,
    output logic              cs_act,
    output logic [CS_W-1:0]   cs_idx,
    output spim_mode_t        mode_cur,
    output logic [DIV_W-1:0]  div_q,
    output logic              done,
    output logic              err
);
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(2 * WORD_W - 1);

    spim_state_e       state;
    logic [EDGE_W-1:0] edge_q;
    logic [GAP_W-1:0]  gcnt;
    logic [GAP_W-1:0]  gap_q;
    logic              last_q;
    spim_mode_t        mode_q;
    logic              legal;
    logic              accept_first;
    logic              accept_next;
    logic              reject;

    assign legal = mode_ok(port_sel[0], mode_in.cpha, 32'(clk_div),
                           SLOW_DIV_MIN, SLOW_DIV_MAX);

    assign accept_first = (state == ST_IDLE) && cmd_valid && port_en && legal;
    assign reject       = (state == ST_IDLE) && cmd_valid && !(port_en && legal);
    assign accept_next  = (state == ST_NEED) && cmd_valid;

    assign load      = accept_first || accept_next;
    assign cmd_ready = (state == ST_IDLE) || (state == ST_NEED);
    assign run       = (state == ST_SHIFT) || (state == ST_GAP) || (state == ST_TAIL);
    assign cs_act    = (state != ST_IDLE);
    assign edge_stb  = (state == ST_SHIFT) && tick;
    assign byte_end  = edge_stb && (edge_q == EDGE_LAST);
    assign edge_idx  = edge_q;
    assign mode_cur  = (state == ST_IDLE) ? mode_in : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            edge_q <= '0;
            gcnt   <= '0;
            gap_q  <= '0;
            last_q <= 1'b0;
            mode_q <= '0;
            div_q  <= '0;
            cs_idx <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= reject;
            unique case (state)
                ST_IDLE: begin
                    if (accept_first) begin
                        mode_q <= mode_in;
                        div_q  <= clk_div;
                        gap_q  <= gap_len;
                        cs_idx <= port_sel[PORT_W-1:1];
                        last_q <= cmd_last;
                        edge_q <= '0;
                        state  <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        edge_q <= edge_q + 1'b1;
                        if (edge_q == EDGE_LAST) begin
                            if (last_q)
                                state <= ST_TAIL;
                            else if (gap_q == '0)
                                state <= ST_NEED;
                            else begin
                                gcnt  <= GAP_W'(1);
                                state <= ST_GAP;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gcnt == gap_q)
                            state <= ST_NEED;
                        else
                            gcnt <= gcnt + 1'b1;
                    end
                end
                ST_NEED: begin
                    if (accept_next) begin
                        last_q <= cmd_last;
                        edge_q <= '0;
                        state  <= ST_SHIFT;
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int WORD_W  = 8,
    localparam int EDGE_W = $clog2(2 * WORD_W),
    localparam int IDX_W  = EDGE_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] data_in,
    input  spim_mode_t        mode,
    input  logic              edge_stb,
    input  logic [EDGE_W-1:0] edge_idx,
    input  logic              byte_end,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] rx_nxt;
    logic [IDX_W-1:0]  k;
    logic              leading;
    logic              sample;
    logic [IDX_W-1:0]  pos_k;
    logic [IDX_W-1:0]  pos_k1;
    logic [IDX_W-1:0]  pos_0;

    assign k       = edge_idx[EDGE_W-1:1];
    assign leading = !edge_idx[0];
    assign sample  = mode.cpha ? !leading : leading;
    assign pos_k   = IDX_W'(bit_slot(32'(k), mode.lsb, WORD_W));
    assign pos_k1  = IDX_W'(bit_slot(32'(k) + 1, mode.lsb, WORD_W));
    assign pos_0   = IDX_W'(bit_slot(0, mode.lsb, WORD_W));

    always_comb begin
        rx_nxt = rx_sh;
        if (edge_stb && sample)
            rx_nxt[pos_k] = miso;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (load) begin
                tx_q  <= data_in;
                rx_sh <= '0;
                sck   <= mode.cpol;
                mosi  <= data_in[pos_0];
            end else if (edge_stb) begin
                sck   <= ~sck;
                rx_sh <= rx_nxt;
                if (!sample) begin
                    if (mode.cpha)
                        mosi <= tx_q[pos_k];
                    else if (32'(k) < WORD_W - 1)
                        mosi <= tx_q[pos_k1];
                end
                if (byte_end) begin
                    rx_data  <= rx_nxt;
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spim_csdrv.sv
module spim_csdrv #(
    parameter int NUM_CS = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic              cs_act,
    input  logic [CS_W-1:0]   cs_idx,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(cs_act && (cs_idx == CS_W'(i)));
    end
endmodule

// File: rtl/spi_multiport_master.sv
module spi_multiport_master
    import spim_pkg::*;
#(
    parameter int NUM_PORTS    = 8,
    parameter int WORD_W       = 8,
    parameter int DIV_W        = 8,
    parameter int GAP_W        = 10,
    parameter int SLOW_DIV_MIN = 4,
    parameter int SLOW_DIV_MAX = 20,
    localparam int NUM_CS      = NUM_PORTS / 2,
    localparam int PORT_W      = $clog2(NUM_PORTS),
    localparam int CS_W        = PORT_W - 1,
    localparam int EDGE_W      = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [PORT_W-1:0] port_sel,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              cmd_last,
    output logic              cmd_ready,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic              done,
    output logic              err,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              bus_oe
);
    spim_mode_t        mode_in;
    spim_mode_t        mode_cur;
    logic              tick;
    logic              load;
    logic              edge_stb;
    logic [EDGE_W-1:0] edge_idx;
    logic              byte_end;
    logic              run;
    logic              cs_act;
    logic [CS_W-1:0]   cs_idx;
    logic [DIV_W-1:0]  div_q;

    assign mode_in = '{cpol: cpol, cpha: cpha, lsb: lsb_first};
    assign bus_oe  = port_en || cs_act;

    spim_ctrl #(
        .WORD_W      (WORD_W),
        .DIV_W       (DIV_W),
        .GAP_W       (GAP_W),
        .PORT_W      (PORT_W),
        .SLOW_DIV_MIN(SLOW_DIV_MIN),
        .SLOW_DIV_MAX(SLOW_DIV_MAX)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .port_en  (port_en),
        .port_sel (port_sel),
        .mode_in  (mode_in),
        .clk_div  (clk_div),
        .gap_len  (gap_len),
        .cmd_valid(cmd_valid),
        .cmd_last (cmd_last),
        .tick     (tick),
        .cmd_ready(cmd_ready),
        .load     (load),
        .edge_stb (edge_stb),
        .edge_idx (edge_idx),
        .byte_end (byte_end),
        .run      (run),
        .cs_act   (cs_act),
        .cs_idx   (cs_idx),
        .mode_cur (mode_cur),
        .div_q    (div_q),
        .done     (done),
        .err      (err)
    );

    spim_tickgen #(.DIV_W(DIV_W)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (run),
        .div (div_q),
        .tick(tick)
    );

    spim_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .data_in (cmd_data),
        .mode    (mode_cur),
        .edge_stb(edge_stb),
        .edge_idx(edge_idx),
        .byte_end(byte_end),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .rx_valid(rx_valid),
        .rx_data (rx_data)
    );

    spim_csdrv #(.NUM_CS(NUM_CS)) u_cs (
        .cs_act(cs_act),
        .cs_idx(cs_idx),
        .cs_n  (cs_n)
    );
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sck,
    input logic              bus_oe,
    input logic              done,
    input logic              err,
    input logic              rx_valid
);
    assert_one_cs_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        err |-> (&cs_n));

    assert_cs_driven_R4: assert property (@(posedge clk) disable iff (rst)
        (!(&cs_n)) |-> bus_oe);

    assert_idle_sck_R5: assert property (@(posedge clk) disable iff (rst)
        ((&cs_n) && $past(&cs_n)) |-> $stable(sck));

    assert_rx_in_frame_R10: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !(&cs_n));

    assert_done_release_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> ((&cs_n) && !(&$past(cs_n))));
endmodule

bind spi_multiport_master spim_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sck     (sck),
    .bus_oe  (bus_oe),
    .done    (done),
    .err     (err),
    .rx_valid(rx_valid)
);

// File: tb/spi_multiport_master_tb.sv
`timescale 1ns/1ps
module spi_multiport_master_tb;
    localparam int NCS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b0;
    logic [2:0] port_sel = '0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       lsb_first = 1'b0;
    logic [7:0] clk_div = '0;
    logic [9:0] gap_len = '0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       cmd_last = 1'b0;
    logic       miso = 1'b0;
    logic       cmd_ready, rx_valid, done, err, sck, mosi, bus_oe;
    logic [7:0] rx_data;
    logic [NCS-1:0] cs_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] txb [4];
    logic [7:0] slv [4];

    always #2.5 clk = ~clk;

    spi_multiport_master u_dut (
        .clk(clk), .rst(rst), .port_en(port_en), .port_sel(port_sel),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .clk_div(clk_div),
        .gap_len(gap_len), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_last(cmd_last), .cmd_ready(cmd_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .done(done), .err(err), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .bus_oe(bus_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int slot(input int k, input bit lsb);
        return lsb ? k : 7 - k;
    endfunction

    // per-cycle reference of one whole transfer; offsets count edges after byte acceptance
    task automatic xfer(input int port, input bit pol, input bit pha, input bit lsb,
                        input int div, input int gap, input int n, input bit poke);
        int h;
        logic [NCS-1:0] cs_on;
        string pre;
        h = div + 1;
        pre = poke ? "R12 " : "";
        cs_on = ~(NCS'(1) << (port / 2));
        @(negedge clk);
        port_en = 1'b1; port_sel = 3'(port); cpol = pol; cpha = pha;
        lsb_first = lsb; clk_div = 8'(div); gap_len = 10'(gap);
        cmd_valid = 1'b1; cmd_data = txb[0]; cmd_last = (n == 1); miso = 1'b0;
        @(negedge clk);
        for (int b = 0; b < n; b++) begin
            bit last;
            int len;
            last = (b == n - 1);
            len = last ? (17 * h + 2) : ((16 + gap) * h + 1);
            for (int m = 0; m < len; m++) begin
                int d, ko, c, ki;
                bit cs_low;
                d = m / h;
                if (d > 16) d = 16;
                ko = pha ? ((d == 0) ? 0 : (d - 1) / 2) : d / 2;
                if (ko > 7) ko = 7;
                cs_low = !(last && m >= 17 * h);
                chk({pre, "R1 cs_n"}, 32'(cs_n), cs_low ? 32'(cs_on) : 32'(4'hF));
                chk({pre, "R5 sck"}, 32'(sck), 32'(pol ^ d[0]));
                chk({pre, pha ? "R7 R8 mosi" : "R6 R8 mosi"}, 32'(mosi),
                    32'(txb[b][slot(ko, lsb)]));
                chk({pre, "R9 cmd_ready"}, 32'(cmd_ready),
                    32'((!last && m == (16 + gap) * h) || (last && m >= 17 * h)));
                chk({pre, "R10 rx_valid"}, 32'(rx_valid), 32'(m == 16 * h));
                if (m == 16 * h)
                    chk({pre, "R10 rx_data"}, 32'(rx_data), 32'(slv[b]));
                chk({pre, "R11 done"}, 32'(done), 32'(last && m == 17 * h));
                if (last && m == 17 * h)
                    chk({pre, "R11 rx_data at done"}, 32'(rx_data), 32'(slv[b]));
                chk({pre, "R4 bus_oe"}, 32'(bus_oe), 32'd1);
                chk({pre, "R2 err"}, 32'(err), 32'd0);
                if (m == 0) begin
                    if (!last) begin
                        cmd_data = txb[b + 1];
                        cmd_last = (b + 1 == n - 1);
                    end else
                        cmd_valid = 1'b0;
                end
                if (poke && b == 0 && m == 3) begin
                    cpol = ~pol; lsb_first = ~lsb; clk_div = 8'(div + 3);
                end
                c = m + 1;
                ki = pha ? ((c < h) ? 0 : (c - h) / (2 * h)) : c / (2 * h);
                if (ki > 7) ki = 7;
                miso = slv[b][slot(ki, lsb)];
                @(negedge clk);
            end
        end
    endtask

    task automatic reject(input string tag, input int port, input bit pha, input int div, input bit en);
        @(negedge clk);
        port_en = en; port_sel = 3'(port); cpol = 1'b0; cpha = pha;
        lsb_first = 1'b0; clk_div = 8'(div); gap_len = '0;
        cmd_valid = 1'b1; cmd_data = 8'hA5; cmd_last = 1'b1;
        @(negedge clk);
        chk({tag, " err pulse"}, 32'(err), 32'd1);
        chk({tag, " cs_n stays high"}, 32'(cs_n), 32'(4'hF));
        chk({tag, " cmd_ready"}, 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk({tag, " err clears"}, 32'(err), 32'd0);
        chk({tag, " no frame"}, 32'(cs_n), 32'(4'hF));
        chk({tag, " R4 bus_oe"}, 32'(bus_oe), 32'(en));
        port_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset cs_n", 32'(cs_n), 32'(4'hF));
        chk("R11 reset done", 32'(done), 32'd0);
        chk("R2 reset err", 32'(err), 32'd0);
        chk("R9 reset cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R4 reset bus_oe", 32'(bus_oe), 32'd0);

        txb = '{8'hC3, 8'h5A, 8'h00, 8'h00};
        slv = '{8'h96, 8'h3C, 8'h00, 8'h00};
        xfer(0, 1'b0, 1'b0, 1'b0, 1, 0, 2, 1'b0);

        txb = '{8'h81, 8'h7E, 8'h2D, 8'h00};
        slv = '{8'hE1, 8'h0F, 8'hB4, 8'h00};
        xfer(3, 1'b0, 1'b1, 1'b1, 5, 2, 3, 1'b0);

        txb = '{8'h6B, 8'h00, 8'h00, 8'h00};
        slv = '{8'hD2, 8'h00, 8'h00, 8'h00};
        xfer(5, 1'b1, 1'b1, 1'b0, 4, 1, 1, 1'b0);

        txb = '{8'h19, 8'hF0, 8'h00, 8'h00};
        slv = '{8'hA7, 8'h4E, 8'h00, 8'h00};
        xfer(6, 1'b1, 1'b0, 1'b1, 0, 3, 2, 1'b1);

        reject("R2 even port cpha1", 2, 1'b1, 5, 1'b1);
        reject("R3 slow div too low", 1, 1'b1, 2, 1'b1);
        reject("R3 slow div too high", 1, 1'b1, 30, 1'b1);
        reject("R4 port disabled", 0, 1'b0, 1, 1'b0);

        txb = '{8'hFF, 8'h01, 8'h80, 8'h55};
        slv = '{8'h00, 8'hFE, 8'h7F, 8'hAA};
        xfer(7, 1'b0, 1'b0, 1'b0, 2, 0, 4, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule